// File: doc/BRIEF.md
# Translation Buffer with Process-Switch Flush

This block is a small, fully associative store of recent virtual-page-to-physical-frame translations. It sits in front of a page-table walker. A requester presents a virtual page number on the lookup port. If a stored tag matches, the frame number comes back combinationally in the same cycle. If nothing matches, the block raises a miss indication. The walker later returns the translation, and it is written in through the fill port, so later references to that page hit.

Tags carry no process identifier. The buffer therefore holds only the current process's translations, and the flush input must be pulsed on every process switch to drop all of them at once.

A fill chooses its entry in this order:
1. An entry that already holds the same page is overwritten in place.
2. Otherwise, the lowest-index empty entry is used.
3. Otherwise, a victim is chosen by a round-robin pointer.

Two wrapping counters of hit and miss lookups are exposed as outputs.

Top module: `xlate_buffer`

## Requirements
- R1: While synchronous active-low reset is applied, all entries become invalid, both counters clear to zero and the victim pointer returns to entry 0.
- R2: When lookup is requested and a valid entry's tag equals all VPN_W bits of the presented page, `lk_hit` is 1 in that same cycle and `lk_pfn` carries that entry's frame.
- R3: A requested lookup that matches no valid entry raises `lk_miss`. `lk_hit` and `lk_miss` are never both 1. Both are 0 and `lk_pfn` is 0 whenever no lookup is requested. `lk_pfn` is also 0 on a miss.
- R4: A fill written at a clock edge is visible to lookups from the next cycle on.
- R5: A fill for an absent page, while some entry is invalid, writes the lowest-index invalid entry.
- R6: A fill for an absent page, while all entries are valid, replaces the entry under the victim pointer. The pointer then advances by one, wrapping from ENTRIES-1 to 0. It moves on no other fill.
- R7: A fill for a page already present rewrites that entry's frame in place. No duplicate tag is ever created.
- R8: A flush invalidates every entry at the next edge and resets the victim pointer to entry 0. It leaves the counters unchanged.
- R9: A fill arriving in the same cycle as a flush is discarded.
- R10: Each cycle with `lk_hit` adds one to `hit_count`, and each cycle with `lk_miss` adds one to `miss_count`. Both wrap modulo 2^CNT_W.
- R11: A lookup in the same cycle as a fill or flush sees the contents held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_miss | output | 1 | Lookup matched nothing |
| lk_pfn | output | PFN_W | Frame of the matching entry, 0 otherwise |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | Page number of the fill |
| fill_pfn | input | PFN_W | Frame number of the fill |
| flush | input | 1 | Invalidate every entry (process switch) |
| hit_count | output | CNT_W | Wrapping count of hit lookups |
| miss_count | output | CNT_W | Wrapping count of missed lookups |

## Verification
Several properties are checked on every cycle:
- hit and miss are mutually exclusive and quiet when no lookup is requested;
- tags stay unique;
- a committed fill is present on the next cycle;
- a flush, with or without a competing fill, leaves no valid entry;
- a fill into free space grows the occupancy by one;
- the victim pointer stays in range and moves on each replacement;
- each counter steps by exactly one per hit or miss.

Only the bench's scenarios can show which entry a fill lands in and when a replaced translation actually disappears. The same holds for the round-robin order across wraps and its restart after a flush, frame rewrites of resident pages, and counter wrap-around. The bench's model tracks entry placement and compares the outputs every cycle.

// File: rtl/xlb_pkg.sv
// Package: shared types for the translation buffer.
// Assumes: nothing; contains only type definitions.
package xlb_pkg;
    // Which rule chose the entry a fill writes.
    typedef enum logic [1:0] {
        WSRC_UPDATE = 2'd0,
        WSRC_FREE   = 2'd1,
        WSRC_VICTIM = 2'd2
    } wsrc_e;
endpackage

// File: rtl/xlb_tag_match.sv
// Module: xlb_tag_match
// Compares one key against every stored tag and returns a per-entry match vector.
// Assumes: tags are packed entry 0 in the low bits; invalid entries never match.
module xlb_tag_match #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 20
) (
    input  logic [ENTRIES-1:0]       valid,
    input  logic [ENTRIES*VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]         key,
    output logic [ENTRIES-1:0]       match
);
    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g*VPN_W +: VPN_W] == key);
    end
endmodule

// File: rtl/xlb_alloc.sv
// Module: xlb_alloc
// Chooses the entry a fill writes (resident page, lowest free entry, then round-robin victim)
// and keeps the victim pointer.
// Assumes: ENTRIES >= 2; fill_match is one-hot or zero; commit is already masked by flush.
module xlb_alloc
    import xlb_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] fill_match,
    input  logic               commit,
    input  logic               flush,
    output logic [IDX_W-1:0]   wr_idx,
    output wsrc_e              wsrc
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] upd_idx;
    logic             free_any;
    logic             upd_any;

    // Priority encoders: lowest invalid entry and the index of the resident match.
    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        upd_idx  = '0;
        upd_any  = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (fill_match[i]) begin
                upd_any = 1'b1;
                upd_idx = IDX_W'(i);
            end
        end
    end

    // Selection: in-place update beats free entry beats victim.
    always_comb begin
        if (upd_any) begin
            wsrc   = WSRC_UPDATE;
            wr_idx = upd_idx;
        end else if (free_any) begin
            wsrc   = WSRC_FREE;
            wr_idx = free_idx;
        end else begin
            wsrc   = WSRC_VICTIM;
            wr_idx = ptr_q;
        end
    end

    // Victim pointer: restarts on reset or flush, steps only on a replacement.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr_q <= '0;
        end else if (commit && (wsrc == WSRC_VICTIM)) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST);
    p_ptr_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && wsrc == WSRC_VICTIM) |=> (ptr_q != $past(ptr_q)));
    p_ptr_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !(commit && wsrc == WSRC_VICTIM)) |=> $stable(ptr_q));
endmodule

// File: rtl/xlb_stats.sv
// Module: xlb_stats
// Counts hit and miss lookups in two wrapping counters.
// Assumes: hit and miss are never both high.
module xlb_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             miss,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    // Counter update; wraps naturally at 2^CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            if (hit)  hit_count  <= hit_count + 1'b1;
            if (miss) miss_count <= miss_count + 1'b1;
        end
    end

    p_hit_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (hit_count == CNT_W'($past(hit_count) + 1'b1)));
    p_miss_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> (miss_count == CNT_W'($past(miss_count) + 1'b1)));
    p_hit_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(hit_count));
endmodule

// File: rtl/xlate_buffer.sv
// Module: xlate_buffer (top)
// Fully associative virtual-page to frame translation store with fill, whole-store flush,
// and hit/miss counters. Lookup is combinational against the registered contents.
// Assumes: ENTRIES >= 2; the requester flushes on every process switch (no process tag).
module xlate_buffer
    import xlb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    parameter int CNT_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             flush,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    logic [ENTRIES-1:0]       valid_q;
    logic [VPN_W-1:0]         tag_q [ENTRIES];
    logic [PFN_W-1:0]         frm_q [ENTRIES];
    logic [ENTRIES*VPN_W-1:0] tag_flat;
    logic [ENTRIES-1:0]       lk_match;
    logic [ENTRIES-1:0]       fill_match;
    logic                     commit;
    logic [IDX_W-1:0]         wr_idx;
    wsrc_e                    wsrc;

    // Flatten tags for the comparators.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign tag_flat[g*VPN_W +: VPN_W] = tag_q[g];
    end

    xlb_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
        .valid(valid_q), .tags(tag_flat), .key(lk_vpn), .match(lk_match)
    );

    xlb_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_match (
        .valid(valid_q), .tags(tag_flat), .key(fill_vpn), .match(fill_match)
    );

    // A fill commits only when no flush competes.
    assign commit = fill_valid && !flush;

    xlb_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk(clk), .rst_n(rst_n), .valid(valid_q), .fill_match(fill_match),
        .commit(commit), .flush(flush), .wr_idx(wr_idx), .wsrc(wsrc)
    );

    // Lookup result: hit/miss flags and OR-mux of the (unique) matching frame.
    always_comb begin
        lk_hit  = lk_valid && (|lk_match);
        lk_miss = lk_valid && !(|lk_match);
        lk_pfn  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_valid && lk_match[i]) lk_pfn = lk_pfn | frm_q[i];
        end
    end

    // Entry storage: flush clears valids, a committed fill writes the chosen entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i] <= '0;
                frm_q[i] <= '0;
            end
        end else if (flush) begin
            valid_q <= '0;
        end else if (commit) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    tag_q[i]   <= fill_vpn;
                    frm_q[i]   <= fill_pfn;
                end
            end
        end
    end

    xlb_stats #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst_n(rst_n), .hit(lk_hit), .miss(lk_miss),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    // Checker-only state: the page of the last committed fill and whether it is resident.
    logic [VPN_W-1:0]   chk_vpn_q;
    logic [ENTRIES-1:0] chk_match;

    // Capture the fill page for the next-cycle residency check.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_vpn_q <= '0;
        else        chk_vpn_q <= fill_vpn;
    end

    xlb_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_chk_match (
        .valid(valid_q), .tags(tag_flat), .key(chk_vpn_q), .match(chk_match)
    );

    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));
    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss && lk_pfn == '0));
    p_fill_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (|chk_match));
    p_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && wsrc == WSRC_FREE) |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));
    p_unique_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match) && $onehot0(fill_match));
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
    p_flush_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && fill_valid) |=> ($countones(valid_q) == 0));
endmodule

// File: tb/tb_xlate_buffer.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of the translation buffer, compared every cycle.
module tb_xlate_buffer;
    localparam int N  = 4;
    localparam int VW = 20;
    localparam int PW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic          lk_hit, lk_miss;
    logic [PW-1:0] lk_pfn;
    logic          fill_valid = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_pfn = '0;
    logic          flush = 1'b0;
    logic [CW-1:0] hit_count, miss_count;

    xlate_buffer #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .flush(flush), .hit_count(hit_count), .miss_count(miss_count)
    );

    always #2 clk = ~clk;

    int    compared = 0;
    int    mismatched = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference model state
    bit m_v[N];
    int m_tag[N];
    int m_frm[N];
    int m_ptr;
    int m_hits;
    int m_miss;

    task automatic check(string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    function automatic int find(int vpn);
        for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == vpn) return i;
        return -1;
    endfunction

    // Model update at each edge, using the pre-edge contents (R11).
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
            m_ptr = 0; m_hits = 0; m_miss = 0;
        end else begin
            if (lk_valid) begin
                if (find(int'(lk_vpn)) >= 0) m_hits = (m_hits + 1) % (1 << CW);
                else                         m_miss = (m_miss + 1) % (1 << CW);
            end
            if (flush) begin
                for (int i = 0; i < N; i++) m_v[i] = 0;
                m_ptr = 0;
            end else if (fill_valid) begin
                int j;
                j = find(int'(fill_vpn));
                if (j < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) j = i;
                if (j < 0) begin
                    j = m_ptr;
                    m_ptr = (m_ptr + 1) % N;
                end
                m_v[j] = 1; m_tag[j] = int'(fill_vpn); m_frm[j] = int'(fill_pfn);
            end
        end
    end

    // Compare all outputs mid-cycle against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int j;
            j = lk_valid ? find(int'(lk_vpn)) : -1;
            check("lk_hit",  int'(lk_hit),  (lk_valid && j >= 0) ? 1 : 0);
            check("lk_miss", int'(lk_miss), (lk_valid && j < 0) ? 1 : 0);
            check("lk_pfn",  int'(lk_pfn),  (j >= 0) ? m_frm[j] : 0);
            check("hit_count (R10)",  int'(hit_count),  m_hits);
            check("miss_count (R10)", int'(miss_count), m_miss);
        end
    end

    task automatic cyc(bit lv, int lv_vpn, bit fv, int f_vpn, int f_pfn, bit fl);
        lk_valid = lv; lk_vpn = VW'(lv_vpn);
        fill_valid = fv; fill_vpn = VW'(f_vpn); fill_pfn = PW'(f_pfn);
        flush = fl;
        @(posedge clk);
        #1;
    endtask

    task automatic look(int vpn);
        cyc(1, vpn, 0, 0, 0, 0);
    endtask

    task automatic fill(int vpn, int pfn);
        cyc(0, 0, 1, vpn, pfn, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        cur_req = "R1";
        lk_valid = 1; lk_vpn = 'h100;
        #1;
        check("lk_hit in reset", int'(lk_hit), 0);
        check("hit_count", int'(hit_count), 0);
        check("miss_count", int'(miss_count), 0);
        lk_valid = 0;
        rst_n = 1;
        @(posedge clk); #1;

        cur_req = "R3";
        look('h100); cyc(0, 'h100, 0, 0, 0, 0); look('h0);

        cur_req = "R11";  // fill and lookup in the same cycle: still a miss
        cyc(1, 'h100, 1, 'h100, 'h21, 0);
        cur_req = "R4";
        look('h100);
        cur_req = "R2";
        look('h100);

        cur_req = "R5";
        fill('h101, 'h22); fill('h102, 'h23); fill('h103, 'h24);
        for (int k = 0; k < 4; k++) look('h100 + k);

        cur_req = "R6";  // full: victims 0,1,2,3,0
        for (int k = 0; k < 5; k++) begin
            fill('h200 + k, 'h40 + k);
            for (int q = 0; q < 4; q++) look('h100 + q);
            look('h200 + k);
        end
        for (int k = 0; k < 5; k++) look('h200 + k);

        cur_req = "R7";  // rewrite a resident page; pointer must not move
        fill('h203, 'h77);
        look('h203);
        fill('h300, 'h50);  // victim should be entry 1 (page 201)
        for (int k = 0; k < 5; k++) look('h200 + k);
        look('h300);

        cur_req = "R11";  // lookup during flush sees old contents
        cyc(1, 'h300, 0, 0, 0, 1);
        cur_req = "R8";
        look('h300); look('h203);
        fill('h400, 'h60); fill('h401, 'h61); fill('h402, 'h62); fill('h403, 'h63);
        fill('h404, 'h64);  // pointer restarted: replaces entry 0
        for (int k = 0; k < 5; k++) look('h400 + k);

        cur_req = "R9";
        cyc(1, 'h401, 1, 'h500, 'h70, 1);
        look('h500); look('h401);

        cur_req = "R10";  // counters wrap at 16
        fill('h600, 'h11);
        for (int k = 0; k < 20; k++) look('h600);
        for (int k = 0; k < 18; k++) look('h601);
        cyc(0, 0, 0, 0, 0, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL %s watchdog actual=hung expected=finished", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule